// File: doc/BRIEF.md
# Interrupt Context Frame Sequencer

This block moves a processor's interrupt context between live registers and a stack held in ordinary word memory. The stack pointer is not a register. It sits in a fixed memory word, so every save or restore starts by reading that word and ends by writing an updated value back to it. All traffic goes through one single-port synchronous memory port. Only one access is in flight at a time.

A save request captures the return program counter, register zero, the status word, an argument word, a new vector and a status mask. The block pushes a four-word frame and advances the pointer by four. It then loads the vector into the program counter, clears register zero and ANDs the status word with the mask. A restore request pops the program counter, register zero and status word from the top frame. The argument slot is skipped and the pointer is rewound by four. Each status update comes with a strobe that tells the interrupt logic to recompute its mask. A memory error ends the sequence at once and raises an error pulse in place of done.

Top module: `ctx_frame_seq`

## Requirements
- R1: A save or restore request accepted at idle starts with a read (memWe=0) of the pointer word at address 97, issued in the cycle after acceptance.
- R2: A save then writes, in this order, the captured return PC to SP, register zero to SP+1, the status word to SP+2 and the argument word to SP+3. SP is the word read in R1. Address arithmetic wraps modulo 2^16. The written values are those present at the request edge.
- R3: A save ends with a write of SP+4 (mod 2^16) to address 97.
- R4: One cycle after the response that completes a save's pointer write, pcWe, reg0We, statusWe, maskUpd and done all pulse for one cycle. In that cycle pcOut is the captured vector, reg0Out is 0 and statusOut is the captured status ANDed with the captured mask.
- R5: A restore reads SP-4, SP-3 and SP-2 in that order, then writes SP-4 to address 97. SP-1 is never accessed.
- R6: One cycle after each restore read response, the matching output pulses with the read data: SP-4 goes to pcOut/pcWe, SP-3 goes to reg0Out/reg0We, and SP-2 goes to statusOut/statusWe together with maskUpd.
- R7: done pulses for exactly one cycle, one cycle after the response that completes a restore's pointer write.
- R8: When memErr answers an access, no further access is issued and no further register strobe occurs. err pulses for one cycle in the next cycle, and done does not pulse.
- R9: A request that arrives while a sequence is in progress is ignored. When both requests are high at idle, the save is taken.
- R10: memReq stays high with address, write enable and write data unchanged until a cycle where memReady or memErr is high. The next access of the sequence starts in the following cycle. After reset every output strobe and memReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| saveReq | input | 1 | Start a context save |
| restoreReq | input | 1 | Start a context restore |
| retPc | input | 16 | Return program counter to push |
| reg0In | input | 16 | Register zero to push |
| statusIn | input | 16 | Status word to push |
| argIn | input | 16 | Argument word to push |
| vecIn | input | 16 | New program counter after save |
| maskIn | input | 16 | Mask ANDed into status after save |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 16 | Word address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memReady |
| memReady | input | 1 | Access completed |
| memErr | input | 1 | Access failed |
| pcOut | output | 16 | New program counter value |
| pcWe | output | 1 | Load pcOut |
| reg0Out | output | 16 | New register zero value |
| reg0We | output | 1 | Load reg0Out |
| statusOut | output | 16 | New status word |
| statusWe | output | 1 | Load statusOut |
| maskUpd | output | 1 | Recompute interrupt mask from status |
| done | output | 1 | Sequence finished |
| err | output | 1 | Sequence aborted by memory error |

## Verification
The first access is due in the cycle after the request edge. Each later access is due in the cycle after the response to the one before it, and it must hold steady for as long as the responder stalls. Register strobes, done and err are all due exactly one cycle after the response that causes them. The bench's memory responder stalls each access by zero to two cycles. At every falling edge it checks memReq, the access fields and every strobe against what the behavioural model predicts for that exact cycle. An early or late pulse therefore fails in the cycle where it does or does not appear.

// File: rtl/ctx_frame_pkg.sv
package ctx_frame_pkg;
  localparam int FRAME_WORDS = 4;
  localparam int POP_WORDS   = 3;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int SLOT_PC     = 0;
  localparam int SLOT_R0     = 1;
  localparam int SLOT_SR     = 2;
  localparam int SLOT_ARG    = 3;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SP_RD,
    ACC_PUSH,
    ACC_POP,
    ACC_SP_SAVE,
    ACC_SP_REST
  } accKind_e;

  typedef struct packed {
    logic             capture;
    accKind_e         kind;
    logic [IDX_W-1:0] idx;
    logic             spLoad;
    logic             popLoad;
    logic             saveCommit;
  } ctlStrobe_t;
endpackage

// File: rtl/ctx_frame_ctrl.sv
module ctx_frame_ctrl
  import ctx_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       saveReq,
  input  logic       restoreReq,
  input  logic       memReady,
  input  logic       memErr,
  output logic       memReq,
  output ctlStrobe_t ctl,
  output logic       done,
  output logic       err
);
  typedef enum logic [2:0] {S_IDLE, S_GET_SP, S_PUSH, S_POP, S_PUT_SP} state_e;

  localparam logic [IDX_W-1:0] LAST_PUSH = IDX_W'(FRAME_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_POP  = IDX_W'(POP_WORDS - 1);

  state_e           state, stateNext;
  logic             isSave, isSaveNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic             ok, fail;

  assign fail   = (state != S_IDLE) && memErr;
  assign ok     = (state != S_IDLE) && memReady && !memErr;
  assign memReq = (state != S_IDLE);

  always_comb begin
    stateNext  = state;
    isSaveNext = isSave;
    idxNext    = idx;
    ctl        = '0;
    ctl.kind   = ACC_NONE;
    ctl.idx    = idx;
    unique case (state)
      S_IDLE: begin
        if (saveReq || restoreReq) begin
          ctl.capture = 1'b1;
          isSaveNext  = saveReq;
          idxNext     = '0;
          stateNext   = S_GET_SP;
        end
      end
      S_GET_SP: begin
        ctl.kind = ACC_SP_RD;
        if (ok) begin
          ctl.spLoad = 1'b1;
          idxNext    = '0;
          stateNext  = isSave ? S_PUSH : S_POP;
        end
      end
      S_PUSH: begin
        ctl.kind = ACC_PUSH;
        if (ok) begin
          if (idx == LAST_PUSH) stateNext = S_PUT_SP;
          else idxNext = idx + 1'b1;
        end
      end
      S_POP: begin
        ctl.kind = ACC_POP;
        if (ok) begin
          ctl.popLoad = 1'b1;
          if (idx == LAST_POP) stateNext = S_PUT_SP;
          else idxNext = idx + 1'b1;
        end
      end
      S_PUT_SP: begin
        ctl.kind = isSave ? ACC_SP_SAVE : ACC_SP_REST;
        if (ok) begin
          ctl.saveCommit = isSave;
          stateNext      = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
    if (fail) stateNext = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      isSave <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      state  <= stateNext;
      isSave <= isSaveNext;
      idx    <= idxNext;
      done   <= (state == S_PUT_SP) && ok;
      err    <= fail;
    end
  end
endmodule

// File: rtl/ctx_frame_dpath.sv
module ctx_frame_dpath
  import ctx_frame_pkg::*;
#(
  parameter int W       = 16,
  parameter int SP_ADDR = 97
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctlStrobe_t   ctl,
  input  logic [W-1:0] retPc,
  input  logic [W-1:0] reg0In,
  input  logic [W-1:0] statusIn,
  input  logic [W-1:0] argIn,
  input  logic [W-1:0] vecIn,
  input  logic [W-1:0] maskIn,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic         memWe,
  output logic [W-1:0] memWdata,
  output logic [W-1:0] pcOut,
  output logic         pcWe,
  output logic [W-1:0] reg0Out,
  output logic         reg0We,
  output logic [W-1:0] statusOut,
  output logic         statusWe,
  output logic         maskUpd
);
  localparam logic [W-1:0] PTR_CELL = W'(SP_ADDR);
  localparam logic [W-1:0] STEP     = W'(FRAME_WORDS);

  logic [W-1:0] frameIn [FRAME_WORDS];
  logic [W-1:0] frame   [FRAME_WORDS];
  logic [W-1:0] sp, vecQ, maskQ, offset;

  assign frameIn[SLOT_PC]  = retPc;
  assign frameIn[SLOT_R0]  = reg0In;
  assign frameIn[SLOT_SR]  = statusIn;
  assign frameIn[SLOT_ARG] = argIn;
  assign offset = {{(W-IDX_W){1'b0}}, ctl.idx};

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame[g] <= '0;
      else if (ctl.capture) frame[g] <= frameIn[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      vecQ  <= '0;
      maskQ <= '0;
    end else begin
      if (ctl.capture) begin
        vecQ  <= vecIn;
        maskQ <= maskIn;
      end
      if (ctl.spLoad) sp <= memRdata;
    end
  end

  always_comb begin
    memAddr  = '0;
    memWe    = 1'b0;
    memWdata = '0;
    unique case (ctl.kind)
      ACC_SP_RD: memAddr = PTR_CELL;
      ACC_PUSH: begin
        memAddr  = sp + offset;
        memWe    = 1'b1;
        memWdata = frame[ctl.idx];
      end
      ACC_POP: memAddr = sp - STEP + offset;
      ACC_SP_SAVE: begin
        memAddr  = PTR_CELL;
        memWe    = 1'b1;
        memWdata = sp + STEP;
      end
      ACC_SP_REST: begin
        memAddr  = PTR_CELL;
        memWe    = 1'b1;
        memWdata = sp - STEP;
      end
      default: memAddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcOut     <= '0;
      reg0Out   <= '0;
      statusOut <= '0;
      pcWe      <= 1'b0;
      reg0We    <= 1'b0;
      statusWe  <= 1'b0;
      maskUpd   <= 1'b0;
    end else begin
      pcWe     <= 1'b0;
      reg0We   <= 1'b0;
      statusWe <= 1'b0;
      maskUpd  <= 1'b0;
      if (ctl.saveCommit) begin
        pcOut     <= vecQ;
        reg0Out   <= '0;
        statusOut <= frame[SLOT_SR] & maskQ;
        pcWe      <= 1'b1;
        reg0We    <= 1'b1;
        statusWe  <= 1'b1;
        maskUpd   <= 1'b1;
      end else if (ctl.popLoad) begin
        unique case (ctl.idx)
          IDX_W'(SLOT_PC): begin
            pcOut <= memRdata;
            pcWe  <= 1'b1;
          end
          IDX_W'(SLOT_R0): begin
            reg0Out <= memRdata;
            reg0We  <= 1'b1;
          end
          IDX_W'(SLOT_SR): begin
            statusOut <= memRdata;
            statusWe  <= 1'b1;
            maskUpd   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctx_frame_seq.sv
module ctx_frame_seq
  import ctx_frame_pkg::*;
#(
  parameter int W       = 16,
  parameter int SP_ADDR = 97
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         saveReq,
  input  logic         restoreReq,
  input  logic [W-1:0] retPc,
  input  logic [W-1:0] reg0In,
  input  logic [W-1:0] statusIn,
  input  logic [W-1:0] argIn,
  input  logic [W-1:0] vecIn,
  input  logic [W-1:0] maskIn,
  output logic         memReq,
  output logic         memWe,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  input  logic [W-1:0] memRdata,
  input  logic         memReady,
  input  logic         memErr,
  output logic [W-1:0] pcOut,
  output logic         pcWe,
  output logic [W-1:0] reg0Out,
  output logic         reg0We,
  output logic [W-1:0] statusOut,
  output logic         statusWe,
  output logic         maskUpd,
  output logic         done,
  output logic         err
);
  ctlStrobe_t ctl;

  ctx_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .memReady(memReady), .memErr(memErr),
    .memReq(memReq), .ctl(ctl), .done(done), .err(err)
  );

  ctx_frame_dpath #(.W(W), .SP_ADDR(SP_ADDR)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .retPc(retPc), .reg0In(reg0In), .statusIn(statusIn), .argIn(argIn),
    .vecIn(vecIn), .maskIn(maskIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .pcOut(pcOut), .pcWe(pcWe), .reg0Out(reg0Out), .reg0We(reg0We),
    .statusOut(statusOut), .statusWe(statusWe), .maskUpd(maskUpd)
  );
endmodule

// File: rtl/ctx_frame_chk.sv
module ctx_frame_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         memReq,
  input logic         memWe,
  input logic [W-1:0] memAddr,
  input logic [W-1:0] memWdata,
  input logic         memReady,
  input logic         memErr,
  input logic         pcWe,
  input logic         reg0We,
  input logic         statusWe,
  input logic [W-1:0] reg0Out,
  input logic         maskUpd,
  input logic         done,
  input logic         err
);
  a_r10_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memReady && !memErr |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memErr |=> !memReq && err && !done && !pcWe && !reg0We && !statusWe);

  a_r6_mask_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    maskUpd |-> statusWe);

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_save_commit: assert property (@(posedge clk) disable iff (!rst_n)
    done && pcWe |-> reg0We && statusWe && maskUpd && (reg0Out == '0));
endmodule

bind ctx_frame_seq ctx_frame_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memReady(memReady), .memErr(memErr), .pcWe(pcWe),
  .reg0We(reg0We), .statusWe(statusWe), .reg0Out(reg0Out), .maskUpd(maskUpd),
  .done(done), .err(err)
);

// File: tb/ctx_frame_seq_tb.sv
`timescale 1ns/1ps
module ctx_frame_seq_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, saveReq, restoreReq, memReady, memErr;
  logic [15:0] retPc, reg0In, statusIn, argIn, vecIn, maskIn, memRdata;
  logic memReq, memWe, pcWe, reg0We, statusWe, maskUpd, done, err;
  logic [15:0] memAddr, memWdata, pcOut, reg0Out, statusOut;

  ctx_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .saveReq(saveReq), .restoreReq(restoreReq),
    .retPc(retPc), .reg0In(reg0In), .statusIn(statusIn), .argIn(argIn),
    .vecIn(vecIn), .maskIn(maskIn), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .memErr(memErr), .pcOut(pcOut), .pcWe(pcWe),
    .reg0Out(reg0Out), .reg0We(reg0We), .statusOut(statusOut),
    .statusWe(statusWe), .maskUpd(maskUpd), .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] a;
    logic        we;
    logic [15:0] d;
    int          eff;
    string       tag;
  } acc_t;

  logic [15:0] mem [256];
  acc_t seqQ[$];
  bit   run = 0;
  bit   active = 0;
  bit   newAcc = 0;
  int   waitLeft = 0;
  int   accCnt = 0;
  int   accNo = 0;
  int   errAt = -1;
  int   reqPend = 0;
  bit   ePc, eR0, eSr, eMask, eDone, eErr;
  logic [15:0] vPc, vR0, vSr, cPc, cSr;
  string eTag;

  task automatic push(input logic [15:0] a, input logic we, input logic [15:0] d,
                      input int eff, input string tag);
    acc_t x;
    x.a = a; x.we = we; x.d = d; x.eff = eff; x.tag = tag;
    seqQ.push_back(x);
  endtask

  task automatic buildSeq(input bit isSave);
    logic [15:0] sp;
    sp = mem[97];
    seqQ.delete();
    accNo  = 0;
    newAcc = 1;
    active = 1;
    push(16'd97, 1'b0, 16'h0, 0, "R1 pointer read");
    if (isSave) begin
      push(sp,         1'b1, retPc,    0, "R2 push pc");
      push(sp + 16'd1, 1'b1, reg0In,   0, "R2 push r0");
      push(sp + 16'd2, 1'b1, statusIn, 0, "R2 push sr");
      push(sp + 16'd3, 1'b1, argIn,    0, "R2 push arg");
      push(16'd97,     1'b1, sp + 16'd4, 5, "R3 pointer advance");
      cPc = vecIn;
      cSr = statusIn & maskIn;
    end else begin
      push(sp - 16'd4, 1'b0, 16'h0, 1, "R5 pop pc");
      push(sp - 16'd3, 1'b0, 16'h0, 2, "R5 pop r0");
      push(sp - 16'd2, 1'b0, 16'h0, 3, "R5 pop sr");
      push(16'd97,     1'b1, sp - 16'd4, 4, "R5 pointer rewind");
    end
  endtask

  initial begin
    bit   wasActive;
    acc_t a;
    logic [15:0] rd;
    wait (run);
    forever begin
      @(negedge clk);
      chk("R10 memReq level", memReq, active);
      if (active && seqQ.size() > 0) begin
        chk({seqQ[0].tag, " addr"}, memAddr, seqQ[0].a);
        chk({seqQ[0].tag, " we"}, memWe, seqQ[0].we);
        if (seqQ[0].we) chk({seqQ[0].tag, " data"}, memWdata, seqQ[0].d);
      end
      chk({eTag, " pcWe"}, pcWe, ePc);
      chk({eTag, " reg0We"}, reg0We, eR0);
      chk({eTag, " statusWe"}, statusWe, eSr);
      chk({eTag, " maskUpd"}, maskUpd, eMask);
      chk({eTag, " done"}, done, eDone);
      chk("R8 err", err, eErr);
      if (ePc) chk({eTag, " pcOut"}, pcOut, vPc);
      if (eR0) chk({eTag, " reg0Out"}, reg0Out, vR0);
      if (eSr) chk({eTag, " statusOut"}, statusOut, vSr);
      {ePc, eR0, eSr, eMask, eDone, eErr} = '0;
      eTag = "R10 idle";

      wasActive = active;
      memReady = 1'b0;
      memErr   = 1'b0;
      memRdata = 16'hDEAD;
      if (active && memReq) begin
        if (newAcc) begin
          waitLeft = accCnt % 3;
          newAcc = 0;
        end
        if (waitLeft == 0) begin
          a = seqQ.pop_front();
          accCnt++;
          newAcc = 1;
          if (accNo == errAt) begin
            memErr = 1'b1;
            eErr   = 1;
            active = 0;
            seqQ.delete();
          end else begin
            memReady = 1'b1;
            rd = mem[a.a[7:0]];
            if (a.we) mem[a.a[7:0]] = a.d;
            else memRdata = rd;
            case (a.eff)
              1: begin ePc = 1; vPc = rd; eTag = "R6"; end
              2: begin eR0 = 1; vR0 = rd; eTag = "R6"; end
              3: begin eSr = 1; eMask = 1; vSr = rd; eTag = "R6"; end
              4: begin eDone = 1; eTag = "R7"; end
              5: begin
                ePc = 1; eR0 = 1; eSr = 1; eMask = 1; eDone = 1;
                vPc = cPc; vR0 = 16'h0; vSr = cSr; eTag = "R4";
              end
              default: ;
            endcase
            if (seqQ.size() == 0) active = 0;
          end
          accNo++;
        end else begin
          waitLeft--;
        end
      end

      saveReq    = (reqPend == 1) || (reqPend == 3);
      restoreReq = (reqPend == 2) || (reqPend == 3);
      if (reqPend != 0 && !wasActive) buildSeq(saveReq);
      reqPend = 0;
    end
  end

  task automatic request(input int kind);
    @(negedge clk);
    reqPend = kind;
    while (reqPend != 0) @(posedge clk);
  endtask

  task automatic waitIdle();
    do @(posedge clk); while (active || reqPend != 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic setIn(input logic [15:0] p, r, s, g, v, m);
    retPc = p; reg0In = r; statusIn = s; argIn = g; vecIn = v; maskIn = m;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
    rst_n = 1'b0; saveReq = 1'b0; restoreReq = 1'b0;
    memReady = 1'b0; memErr = 1'b0; memRdata = 16'h0;
    setIn(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    eTag = "R10 idle";
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 reset memReq", memReq, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset err", err, 0);
    chk("R10 reset strobes", {pcWe, reg0We, statusWe, maskUpd}, 0);
    rst_n = 1'b1;
    run = 1;

    mem[97] = 16'h0040;
    setIn(16'h1234, 16'hA5A5, 16'hFFFF, 16'h0077, 16'h0200, 16'h00F0);
    request(1);
    waitIdle();
    chk("R2 frame pc", mem[8'h40], 16'h1234);
    chk("R2 frame arg", mem[8'h43], 16'h0077);
    chk("R3 pointer", mem[97], 16'h0044);

    setIn(16'h0300, 16'h0001, 16'h8421, 16'h5555, 16'h0400, 16'hFF0F);
    request(1);
    waitIdle();
    chk("R3 nested pointer", mem[97], 16'h0048);
    request(2);
    waitIdle();
    request(2);
    waitIdle();
    chk("R5 pointer rewound", mem[97], 16'h0040);

    mem[97] = 16'hFFFE;
    setIn(16'hBEEF, 16'h0F0F, 16'h00FF, 16'h9999, 16'h0010, 16'h003C);
    request(1);
    waitIdle();
    chk("R3 wrap pointer", mem[97], 16'h0002);
    request(2);
    waitIdle();
    chk("R5 wrap rewind", mem[97], 16'hFFFE);

    mem[97] = 16'h0080;
    setIn(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666);
    request(3);
    waitIdle();
    chk("R9 save wins", mem[97], 16'h0084);

    request(2);
    repeat (3) @(posedge clk);
    request(1);
    waitIdle();
    chk("R9 busy request ignored", mem[97], 16'h0080);

    keep = mem[97];
    errAt = 2;
    request(1);
    waitIdle();
    chk("R8 pointer kept after save abort", mem[97], keep);
    mem[97] = 16'h0084;
    errAt = 3;
    request(2);
    waitIdle();
    chk("R8 pointer kept after restore abort", mem[97], 16'h0084);
    errAt = 0;
    request(2);
    waitIdle();
    errAt = -1;
    request(2);
    waitIdle();
    chk("R5 pointer after clean restore", mem[97], 16'h0080);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule